// File: doc/BRIEF.md
# Two-Channel Interrupt Vector Arbiter

This block keeps the interrupt bookkeeping for a pair of serial channels, called A (index 0) and B (index 1). For each channel it tracks whether a receive or a transmit interrupt is pending and which of them is in service. From that state it builds three results. The first is a shared pending-source register. The second is a vector register whose value reports the highest source most recently raised. The third is one registered interrupt request line that is the OR of the two channels' requests.

The channel logic reacts to these inputs:
- receive-character events
- transmit-buffer-empty events
- data-port reads and writes
- a three-bit command field
- live enable fields (transmit enable, a two-bit receive mode, and break enable with a break status input)

A receive interrupt takes precedence over a transmit interrupt. While a receive interrupt is in service, a transmit interrupt can become pending but cannot enter service, cannot change the vector and cannot set its pending-register bit. Clearing one source raises the other again if that other source is still pending.

Each channel holds a service state machine with four states:
- `SVC_NONE`: nothing in service.
- `SVC_TX`: transmit in service.
- `SVC_RX`: receive in service.
- `SVC_RX_TX`: receive raised on top of a transmit already in service.

The transitions are:
- raise-receive: NONE→RX, TX→RX_TX.
- raise-transmit: NONE→TX. It is ignored while receive is in service.
- clear-receive: RX→NONE, RX_TX→TX.
- clear-transmit: TX→NONE, RX_TX→RX.
- reset-highest: RX→NONE, RX_TX→TX, TX→NONE. If receive was in service and transmit is still pending, raise-transmit follows.

Top module: `two_ch_irq_arb`

## Requirements
- R1: After reset, `irq`, `pend_reg`, `vec_reg` and `rx_avail` are all zero.
- R2: A receive event on a channel sets that channel's `rx_avail` bit and its receive pending-register bit, puts receive in service and loads that channel's receive vector. The pending-register bits are: 5 A receive, 4 A transmit, 2 B receive, 1 B transmit; bits 7:6, 3 and 0 are always zero.
- R3: A transmit raise (a buffer-empty event or a data write) marks transmit pending. Only when receive is not in service does it also put transmit in service and load the transmit vector. In that case it sets the transmit pending-register bit, but only if `tx_ie` for that channel is 1.
- R4: With `status_hi`=0 the vector codes are: A receive 0x0C, A transmit 0x08, B receive 0x04, B transmit 0x00, no source 0x06.
- R5: With `status_hi`=1 the vector codes are: A receive 0x30, A transmit 0x10, B receive 0x20, B transmit 0x00, no source 0x60.
- R6: A channel requests an interrupt when any of these holds: `tx_ie` is 1 and transmit is pending; the receive mode is 01 or 10 and receive is pending; break enable and break status are both 1. `irq` is the OR of both channels' requests and is registered, so it shows the state and inputs of the previous clock edge.
- R7: Command code 7 (reset highest in service) does one of two things. If receive is in service, it takes receive out of service and raises transmit again if transmit is pending. Otherwise it takes transmit out of service.
- R8: Command code 5 clears transmit pending, takes transmit out of service, clears the transmit pending-register bit and loads the no-source vector. It then raises receive again if receive is pending.
- R9: A data read clears `rx_avail`, clears receive pending, takes receive out of service, clears the receive pending-register bit and loads the no-source vector. It then raises transmit again if transmit is pending.
- R10: Within one channel in one cycle, the actions apply in this order: receive event, data read, command, data write, transmit event. When both channels load the vector in the same cycle, channel A's value is kept.
- R11: Command codes other than 5 and 7 change no output.
- R12: Break status reaches `irq` only while break enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_hi | input | 1 | Selects the high-bit vector layout |
| rx_char_ev | input | 2 | Receive character event per channel |
| tx_empty_ev | input | 2 | Transmit buffer empty event per channel |
| data_rd | input | 2 | Data port read strobe per channel |
| data_wr | input | 2 | Data port write strobe per channel |
| cmd_wr | input | 2 | Command strobe per channel |
| cmd_a | input | 3 | Command code for channel A |
| cmd_b | input | 3 | Command code for channel B |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode_a | input | 2 | Receive interrupt mode, channel A |
| rx_mode_b | input | 2 | Receive interrupt mode, channel B |
| brk_ie | input | 2 | Break interrupt enable per channel |
| brk_st | input | 2 | Break status per channel |
| irq | output | 1 | Combined registered interrupt request |
| pend_reg | output | 8 | Pending-source register |
| vec_reg | output | 8 | Interrupt vector register |
| rx_avail | output | 2 | Receive character available per channel |

## Verification
Every result is due one clock edge after the inputs that cause it. The pending register, vector, `rx_avail` and `irq` all change at the edge that samples the strobe, and `irq` also reflects the enable and break levels present at that edge. The bench drives inputs just after a rising edge and samples all four outputs 1 ns after the next rising edge. A behavioural model updates at the same edge, and the outputs are compared against it there. Directed sequences cover several cases: receive blocking transmit, each command, both vector layouts, same-cycle collisions and break. A random phase then mixes all strobes.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int VEC_W = 8;
    localparam int CMD_W = 3;
    localparam int NCH   = 2;

    localparam logic [CMD_W-1:0] CMD_CLR_TX  = 3'd5;
    localparam logic [CMD_W-1:0] CMD_RST_IUS = 3'd7;

    typedef enum logic [1:0] {
        SVC_NONE  = 2'd0,
        SVC_TX    = 2'd1,
        SVC_RX    = 2'd2,
        SVC_RX_TX = 2'd3
    } svc_e;

    typedef enum logic [1:0] {
        SRC_RX   = 2'd0,
        SRC_TX   = 2'd1,
        SRC_NONE = 2'd2
    } src_e;

    typedef struct packed {
        svc_e             svc;
        logic             rxp;
        logic             txp;
        logic             prx;
        logic             ptx;
        logic             av;
        logic             we;
        logic [VEC_W-1:0] vec;
    } chan_st_t;

    function automatic logic [VEC_W-1:0] vec_code(logic is_a, logic hi, src_e k);
        logic [VEC_W-1:0] v;
        v = '0;
        unique case (k)
            SRC_RX:   v = is_a ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
            SRC_TX:   v = is_a ? (hi ? 8'h10 : 8'h08) : 8'h00;
            SRC_NONE: v = hi ? 8'h60 : 8'h06;
            default:  v = '0;
        endcase
        return v;
    endfunction

    function automatic logic rx_in_svc(svc_e s);
        return (s == SVC_RX) || (s == SVC_RX_TX);
    endfunction

endpackage

// File: rtl/irq_chan.sv
module irq_chan
    import irq_arb_pkg::*;
#(
    parameter bit IS_CH_A = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             status_hi,
    input  logic             rx_ev,
    input  logic             tx_ev,
    input  logic             rd,
    input  logic             wr,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd,
    input  logic             tx_ie,
    input  logic [1:0]       rx_mode,
    input  logic             brk_ie,
    input  logic             brk_st,
    output logic             rx_avail,
    output logic             pend_rx,
    output logic             pend_tx,
    output logic             vec_we,
    output logic [VEC_W-1:0] vec_val,
    output logic             req_next
);

    chan_st_t cur_q;
    chan_st_t nxt;

    function automatic chan_st_t op_set_rx(chan_st_t st, logic hi);
        chan_st_t r;
        r     = st;
        r.rxp = 1'b1;
        r.prx = 1'b1;
        unique case (st.svc)
            SVC_NONE:  r.svc = SVC_RX;
            SVC_TX:    r.svc = SVC_RX_TX;
            SVC_RX:    r.svc = SVC_RX;
            SVC_RX_TX: r.svc = SVC_RX_TX;
            default:   r.svc = SVC_RX;
        endcase
        r.we  = 1'b1;
        r.vec = vec_code(IS_CH_A, hi, SRC_RX);
        return r;
    endfunction

    function automatic chan_st_t op_set_tx(chan_st_t st, logic hi, logic ie);
        chan_st_t r;
        r     = st;
        r.txp = 1'b1;
        if (!rx_in_svc(st.svc)) begin
            r.svc = SVC_TX;
            if (ie) r.ptx = 1'b1;
            r.we  = 1'b1;
            r.vec = vec_code(IS_CH_A, hi, SRC_TX);
        end
        return r;
    endfunction

    function automatic chan_st_t op_clr_rx(chan_st_t st, logic hi, logic ie);
        chan_st_t r;
        r     = st;
        r.rxp = 1'b0;
        r.prx = 1'b0;
        unique case (st.svc)
            SVC_NONE:  r.svc = SVC_NONE;
            SVC_TX:    r.svc = SVC_TX;
            SVC_RX:    r.svc = SVC_NONE;
            SVC_RX_TX: r.svc = SVC_TX;
            default:   r.svc = SVC_NONE;
        endcase
        r.we  = 1'b1;
        r.vec = vec_code(IS_CH_A, hi, SRC_NONE);
        if (r.txp) r = op_set_tx(r, hi, ie);
        return r;
    endfunction

    function automatic chan_st_t op_clr_tx(chan_st_t st, logic hi);
        chan_st_t r;
        r     = st;
        r.txp = 1'b0;
        r.ptx = 1'b0;
        unique case (st.svc)
            SVC_NONE:  r.svc = SVC_NONE;
            SVC_TX:    r.svc = SVC_NONE;
            SVC_RX:    r.svc = SVC_RX;
            SVC_RX_TX: r.svc = SVC_RX;
            default:   r.svc = SVC_NONE;
        endcase
        r.we  = 1'b1;
        r.vec = vec_code(IS_CH_A, hi, SRC_NONE);
        if (r.rxp) r = op_set_rx(r, hi);
        return r;
    endfunction

    function automatic chan_st_t op_rst_ius(chan_st_t st, logic hi, logic ie);
        chan_st_t r;
        r = st;
        unique case (st.svc)
            SVC_RX: begin
                r.svc = SVC_NONE;
                if (r.txp) r = op_set_tx(r, hi, ie);
            end
            SVC_RX_TX: begin
                r.svc = SVC_TX;
                if (r.txp) r = op_set_tx(r, hi, ie);
            end
            SVC_TX:   r.svc = SVC_NONE;
            SVC_NONE: r.svc = SVC_NONE;
            default:  r.svc = SVC_NONE;
        endcase
        return r;
    endfunction

    // next-state: ordered actions within one cycle
    always_comb begin
        chan_st_t s;
        s    = cur_q;
        s.we = 1'b0;
        if (rx_ev) begin
            s.av = 1'b1;
            s    = op_set_rx(s, status_hi);
        end
        if (rd) begin
            s.av = 1'b0;
            s    = op_clr_rx(s, status_hi, tx_ie);
        end
        if (cmd_wr) begin
            unique case (cmd)
                CMD_CLR_TX:  s = op_clr_tx(s, status_hi);
                CMD_RST_IUS: s = op_rst_ius(s, status_hi, tx_ie);
                default:     s = s;
            endcase
        end
        if (wr) begin
            s.txp = 1'b0;
            s     = op_set_tx(s, status_hi, tx_ie);
        end
        if (tx_ev) begin
            s = op_set_tx(s, status_hi, tx_ie);
        end
        nxt = s;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.svc <= SVC_NONE;
            cur_q.rxp <= 1'b0;
            cur_q.txp <= 1'b0;
            cur_q.prx <= 1'b0;
            cur_q.ptx <= 1'b0;
            cur_q.av  <= 1'b0;
            cur_q.we  <= 1'b0;
            cur_q.vec <= '0;
        end else begin
            cur_q <= nxt;
        end
    end

    // outputs
    always_comb begin
        rx_avail = cur_q.av;
        pend_rx  = cur_q.prx;
        pend_tx  = cur_q.ptx;
        vec_we   = nxt.we;
        vec_val  = nxt.vec;
        req_next = (tx_ie && nxt.txp)
                 || (((rx_mode == 2'b01) || (rx_mode == 2'b10)) && nxt.rxp)
                 || (brk_ie && brk_st);
    end

endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge
    import irq_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   we,
    input  logic [VEC_W-1:0] val_a,
    input  logic [VEC_W-1:0] val_b,
    input  logic [NCH-1:0]   req,
    input  logic [NCH-1:0]   prx,
    input  logic [NCH-1:0]   ptx,
    output logic [VEC_W-1:0] vec_q,
    output logic [7:0]       pend,
    output logic             irq_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= |req;
            if (we[0])      vec_q <= val_a;
            else if (we[1]) vec_q <= val_b;
        end
    end

    assign pend = {2'b00, prx[0], ptx[0], 1'b0, prx[1], ptx[1], 1'b0};

endmodule

// File: rtl/two_ch_irq_arb.sv
module two_ch_irq_arb
    import irq_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             status_hi,
    input  logic [1:0]       rx_char_ev,
    input  logic [1:0]       tx_empty_ev,
    input  logic [1:0]       data_rd,
    input  logic [1:0]       data_wr,
    input  logic [1:0]       cmd_wr,
    input  logic [2:0]       cmd_a,
    input  logic [2:0]       cmd_b,
    input  logic [1:0]       tx_ie,
    input  logic [1:0]       rx_mode_a,
    input  logic [1:0]       rx_mode_b,
    input  logic [1:0]       brk_ie,
    input  logic [1:0]       brk_st,
    output logic             irq,
    output logic [7:0]       pend_reg,
    output logic [7:0]       vec_reg,
    output logic [1:0]       rx_avail
);

    logic [CMD_W-1:0] cmd_arr  [NCH];
    logic [1:0]       mode_arr [NCH];
    logic [VEC_W-1:0] vval     [NCH];
    logic [NCH-1:0]   vwe, req, prx, ptx;

    assign cmd_arr[0]  = cmd_a;
    assign cmd_arr[1]  = cmd_b;
    assign mode_arr[0] = rx_mode_a;
    assign mode_arr[1] = rx_mode_b;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        irq_chan #(.IS_CH_A(g == 0)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .status_hi(status_hi),
            .rx_ev    (rx_char_ev[g]),
            .tx_ev    (tx_empty_ev[g]),
            .rd       (data_rd[g]),
            .wr       (data_wr[g]),
            .cmd_wr   (cmd_wr[g]),
            .cmd      (cmd_arr[g]),
            .tx_ie    (tx_ie[g]),
            .rx_mode  (mode_arr[g]),
            .brk_ie   (brk_ie[g]),
            .brk_st   (brk_st[g]),
            .rx_avail (rx_avail[g]),
            .pend_rx  (prx[g]),
            .pend_tx  (ptx[g]),
            .vec_we   (vwe[g]),
            .vec_val  (vval[g]),
            .req_next (req[g])
        );
    end

    irq_vec_merge u_merge (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (vwe),
        .val_a(vval[0]),
        .val_b(vval[1]),
        .req  (req),
        .prx  (prx),
        .ptx  (ptx),
        .vec_q(vec_reg),
        .pend (pend_reg),
        .irq_q(irq)
    );

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rx_char_ev,
    input logic [1:0] tx_empty_ev,
    input logic [1:0] data_rd,
    input logic [1:0] data_wr,
    input logic [1:0] cmd_wr,
    input logic [2:0] cmd_a,
    input logic [1:0] tx_ie,
    input logic [1:0] brk_ie,
    input logic [1:0] brk_st,
    input logic       irq,
    input logic [7:0] pend_reg,
    input logic [7:0] vec_reg,
    input logic [1:0] rx_avail
);

    // R2
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_char_ev[0] && !data_rd[0]) |=> (rx_avail[0] && pend_reg[5]));

    // R9
    rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd[1] |=> (!rx_avail[1] && !pend_reg[2]));

    // R12
    brk_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_ie[0] && brk_st[0]) |=> irq);

    // R3
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_reg[4]) |-> $past(tx_ie[0]));

    // R8
    clr_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr[0] && cmd_a == 3'd5 && !data_wr[0] && !tx_empty_ev[0]) |=> !pend_reg[4]);

    // R4
    vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_reg inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h60});

endmodule

bind two_ch_irq_arb irq_arb_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_char_ev (rx_char_ev),
    .tx_empty_ev(tx_empty_ev),
    .data_rd    (data_rd),
    .data_wr    (data_wr),
    .cmd_wr     (cmd_wr),
    .cmd_a      (cmd_a),
    .tx_ie      (tx_ie),
    .brk_ie     (brk_ie),
    .brk_st     (brk_st),
    .irq        (irq),
    .pend_reg   (pend_reg),
    .vec_reg    (vec_reg),
    .rx_avail   (rx_avail)
);

// File: tb/sim_two_ch_irq_arb.sv
`timescale 1ns/1ps
module sim_two_ch_irq_arb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       status_hi = 1'b0;
    logic [1:0] rx_char_ev = '0, tx_empty_ev = '0, data_rd = '0, data_wr = '0, cmd_wr = '0;
    logic [2:0] cmd_a = '0, cmd_b = '0;
    logic [1:0] tx_ie = '0, rx_mode_a = '0, rx_mode_b = '0, brk_ie = '0, brk_st = '0;
    logic       irq;
    logic [7:0] pend_reg, vec_reg;
    logic [1:0] rx_avail;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk;

    two_ch_irq_arb u0 (.*);

    // behavioural reference model
    bit m_rxp[2], m_txp[2], m_rs[2], m_ts[2], m_pr[2], m_pt[2], m_av[2];
    bit m_irq;
    logic [7:0] m_vec;
    logic [7:0] pv[2];
    bit pw[2];

    function automatic logic [7:0] code(int ch, int kind, bit hi);
        // kind 0 rx, 1 tx, 2 none
        if (kind == 2) return hi ? 8'h60 : 8'h06;
        if (ch == 0) begin
            if (kind == 0) return hi ? 8'h30 : 8'h0C;
            return hi ? 8'h10 : 8'h08;
        end
        if (kind == 0) return hi ? 8'h20 : 8'h04;
        return 8'h00;
    endfunction

    task automatic raise_rx(int c);
        m_rxp[c] = 1; m_rs[c] = 1; m_pr[c] = 1;
        pw[c] = 1; pv[c] = code(c, 0, status_hi);
    endtask

    task automatic raise_tx(int c);
        m_txp[c] = 1;
        if (!m_rs[c]) begin
            m_ts[c] = 1;
            if (tx_ie[c]) m_pt[c] = 1;
            pw[c] = 1; pv[c] = code(c, 1, status_hi);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_rxp[c] = 0; m_txp[c] = 0; m_rs[c] = 0; m_ts[c] = 0;
                m_pr[c] = 0; m_pt[c] = 0; m_av[c] = 0;
            end
            m_vec = 8'h00; m_irq = 0;
        end else begin
            bit r;
            r = 0;
            for (int c = 0; c < 2; c++) begin
                logic [2:0] cc;
                logic [1:0] md;
                cc = (c == 0) ? cmd_a : cmd_b;
                md = (c == 0) ? rx_mode_a : rx_mode_b;
                pw[c] = 0;
                if (rx_char_ev[c]) begin m_av[c] = 1; raise_rx(c); end
                if (data_rd[c]) begin
                    m_av[c] = 0; m_rxp[c] = 0; m_rs[c] = 0; m_pr[c] = 0;
                    pw[c] = 1; pv[c] = code(c, 2, status_hi);
                    if (m_txp[c]) raise_tx(c);
                end
                if (cmd_wr[c] && cc == 3'd5) begin
                    m_txp[c] = 0; m_ts[c] = 0; m_pt[c] = 0;
                    pw[c] = 1; pv[c] = code(c, 2, status_hi);
                    if (m_rxp[c]) raise_rx(c);
                end
                if (cmd_wr[c] && cc == 3'd7) begin
                    if (m_rs[c]) begin
                        m_rs[c] = 0;
                        if (m_txp[c]) raise_tx(c);
                    end else m_ts[c] = 0;
                end
                if (data_wr[c]) begin m_txp[c] = 0; raise_tx(c); end
                if (tx_empty_ev[c]) raise_tx(c);
                if ((tx_ie[c] && m_txp[c]) || ((md == 2'b01 || md == 2'b10) && m_rxp[c])
                    || (brk_ie[c] && brk_st[c])) r = 1;
            end
            if (pw[0]) m_vec = pv[0];
            else if (pw[1]) m_vec = pv[1];
            m_irq = r;
        end
    end

    task automatic chk(string t, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic cmp_model();
        chk({tag, " irq"}, {7'b0, irq}, {7'b0, m_irq});
        chk({tag, " vec"}, vec_reg, m_vec);
        chk({tag, " pend"}, pend_reg, {2'b00, m_pr[0], m_pt[0], 1'b0, m_pr[1], m_pt[1], 1'b0});
        chk({tag, " rx_avail"}, {6'b0, rx_avail}, {6'b0, m_av[1], m_av[0]});
    endtask

    task automatic clr_ev();
        rx_char_ev = '0; tx_empty_ev = '0; data_rd = '0; data_wr = '0; cmd_wr = '0;
    endtask

    // one cycle: inputs set before the call are sampled at the next edge
    task automatic tick();
        @(posedge clk); #1;
        cmp_model();
        clr_ev();
    endtask

    task automatic cmd(int c, logic [2:0] code_v);
        cmd_wr[c] = 1'b1;
        if (c == 0) cmd_a = code_v; else cmd_b = code_v;
        tick();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        tag = "R1";
        chk("R1 vec", vec_reg, 8'h00);
        chk("R1 pend", pend_reg, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 rx_avail", {6'b0, rx_avail}, 8'h00);
        rst_n = 1'b1;
        tx_ie = 2'b11; rx_mode_a = 2'b01; rx_mode_b = 2'b01;
        tick();

        // R2 R4: receive on A
        tag = "R2"; rx_char_ev[0] = 1; tick();
        chk("R2 vec", vec_reg, 8'h0C); chk("R2 pend", pend_reg, 8'h20);
        chk("R6 irq", {7'b0, irq}, 8'h01);
        // R3: transmit blocked by receive in service
        tag = "R3"; tx_empty_ev[0] = 1; tick();
        chk("R3 vec", vec_reg, 8'h0C); chk("R3 pend", pend_reg, 8'h20);
        // R7: reset highest in service re-raises transmit
        tag = "R7"; cmd(0, 3'd7);
        chk("R7 vec", vec_reg, 8'h08); chk("R7 pend", pend_reg, 8'h30);
        // R9: read
        tag = "R9"; data_rd[0] = 1; tick();
        chk("R9 vec", vec_reg, 8'h08); chk("R9 pend", pend_reg, 8'h10);
        chk("R9 rx_avail", {6'b0, rx_avail}, 8'h00);
        // R8: clear transmit
        tag = "R8"; cmd(0, 3'd5);
        chk("R8 vec", vec_reg, 8'h06); chk("R8 pend", pend_reg, 8'h00);
        tick(); chk("R8 irq", {7'b0, irq}, 8'h00);

        // R4 channel B
        tag = "R4"; rx_char_ev[1] = 1; tick(); chk("R4 vec rxB", vec_reg, 8'h04);
        tx_empty_ev[1] = 1; tick(); chk("R4 vec held", vec_reg, 8'h04);
        cmd(1, 3'd7); chk("R4 vec txB", vec_reg, 8'h00);
        data_rd[1] = 1; tick(); chk("R4 pend", pend_reg, 8'h02);
        cmd(1, 3'd5); chk("R4 vec none", vec_reg, 8'h06);

        // R5 high layout
        tag = "R5"; status_hi = 1;
        rx_char_ev[0] = 1; tick(); chk("R5 vec rxA", vec_reg, 8'h30);
        tx_empty_ev[0] = 1; tick();
        data_rd[0] = 1; tick(); chk("R5 vec txA", vec_reg, 8'h10);
        cmd(0, 3'd5); chk("R5 vec none", vec_reg, 8'h60);
        rx_char_ev[1] = 1; tick(); chk("R5 vec rxB", vec_reg, 8'h20);
        data_rd[1] = 1; tick(); chk("R5 vec none B", vec_reg, 8'h60);
        status_hi = 0;

        // R3 R10 write with transmit enable off
        tag = "R3"; tx_ie = 2'b00; data_wr[0] = 1; tick();
        chk("R3 vec wr", vec_reg, 8'h08); chk("R3 pend ie0", pend_reg, 8'h00);
        tick(); chk("R6 irq ie0", {7'b0, irq}, 8'h00);
        cmd(0, 3'd5); tx_ie = 2'b11;

        // R10 same-cycle ordering
        tag = "R10"; rx_char_ev[0] = 1; tx_empty_ev[0] = 1; tick();
        chk("R10 vec", vec_reg, 8'h0C); chk("R10 pend", pend_reg, 8'h20);
        data_rd[0] = 1; tick(); chk("R10 pend rd", pend_reg, 8'h10);
        cmd(0, 3'd5);
        rx_char_ev = 2'b11; tick();
        chk("R10 vec A wins", vec_reg, 8'h0C); chk("R10 pend both", pend_reg, 8'h24);
        data_rd = 2'b11; tick(); chk("R10 pend clr", pend_reg, 8'h00);

        // R11 other command codes
        tag = "R11"; rx_char_ev[0] = 1; tick();
        for (int k = 0; k < 7; k++) begin
            if (k != 5) begin
                cmd(0, 3'(k));
                chk("R11 vec", vec_reg, 8'h0C); chk("R11 pend", pend_reg, 8'h20);
            end
        end

        // R6 receive modes, R12 break
        tag = "R6"; rx_mode_a = 2'b11; tick(); chk("R6 mode11", {7'b0, irq}, 8'h00);
        rx_mode_a = 2'b10; tick(); chk("R6 mode10", {7'b0, irq}, 8'h01);
        data_rd[0] = 1; tick(); tick(); chk("R6 idle", {7'b0, irq}, 8'h00);
        tag = "R12"; brk_st = 2'b10; tick(); chk("R12 no en", {7'b0, irq}, 8'h00);
        brk_ie = 2'b10; tick(); chk("R12 en", {7'b0, irq}, 8'h01);
        brk_ie = 2'b00; brk_st = 2'b00; tick();

        // random mix against the model
        tag = "R10 random";
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            rx_char_ev  = (r[1:0]   & {r[2], r[3]});
            tx_empty_ev = r[5:4]  & {r[6], r[7]};
            data_rd     = r[9:8]  & {r[10], r[11]};
            data_wr     = r[13:12] & {r[14], r[15]};
            cmd_wr      = r[17:16] & {r[18], r[19]};
            cmd_a       = r[22:20];
            cmd_b       = r[25:23];
            if (r[26] && r[27]) tx_ie = $urandom_range(0, 3);
            if (r[28] && r[27]) rx_mode_a = $urandom_range(0, 3);
            if (r[29] && r[27]) rx_mode_b = $urandom_range(0, 3);
            if (r[30] && r[31] && r[27]) status_hi = ~status_hi;
            brk_st = (i % 97 == 0) ? 2'b11 : 2'b00;
            brk_ie = (i % 2 == 0) ? 2'b01 : 2'b10;
            tick();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule